// File: doc/BRIEF.md
# Serial Line Delay Meter

This block measures the propagation delay of a clocked serial encoder link once at power-up, before normal traffic starts, and again whenever a start pulse asks for it. It drives a slow interface clock and sends a plain position-read command to the encoder. While the clock runs, it stamps every rising edge of the clock against a free-running counter on the fast reference clock. After the command it listens for the encoder's start bit and records how many reference ticks passed between the most recent rising clock edge and the arrival of that bit.

Each measurement consists of several runs, three by default. The compensation value is the integer quotient of the sum of the runs divided by the number of runs. The block also compares the largest and smallest run. When they are further apart than one eighth of the interface clock period, the result is marked unreliable. A run in which no start bit arrives ends the measurement with a timeout flag.

The result is a held value, not a stream. It stays on the outputs until the next measurement writes it, so it has no handshake and no back-pressure. The host only reads it after the done pulse.

Top module: `line_delay_meter`

## Requirements
- R1: Once reset is released, a measurement begins within one reference cycle with no start pulse (`meas_busy` goes high).
- R2: `enc_clk` is high while idle, between runs and after a run ends. While a run is active it toggles every `HALF_PERIOD` reference cycles, so its period is 2·`HALF_PERIOD` cycles, and its first edge is falling.
- R3: During the first eight falling edges of a run `enc_cmd_oe` is high. On each of those edges `enc_cmd` takes the next value of the sequence 0,0,0,0,0,1,1,1: two lead bits, then the 3-bit command sent with its redundant copy as 000111. On the ninth falling edge `enc_cmd_oe` drops and listening begins.
- R4: The value of one run, in reference ticks, is the number of reference edges from the edge that raised `enc_clk` most recently to the first edge that samples `data_in` high, plus one for the second synchronizer stage. When data rises d cycles after a rising clock edge, the value is d+2.
- R5: `delay_ticks` becomes the sum of the run values divided by `RUNS`, rounded down.
- R6: The result is marked unreliable when the maximum run value minus the minimum run value exceeds (2·`HALF_PERIOD`)/8. In that case `meas_unreliable`=1 and `meas_valid`=0. Otherwise `meas_valid`=1 and `meas_unreliable`=0. `delay_ticks` is updated in both cases.
- R7: If no start bit arrives by `TMO_PERIODS` falling edges after listening begins, the measurement ends with `meas_timeout`=1 and `meas_valid`=0. `delay_ticks` keeps its previous value and the clock parks high.
- R8: `meas_done` is a one-cycle pulse issued when `meas_busy` falls. The results are held until the next start. A new start clears the three flags on the edge that accepts it and leaves `delay_ticks` unchanged.
- R9: A start pulse that arrives while busy is ignored. It is not queued either, so no further frame follows the measurement.
- R10: `meas_done` rises SUM_W+3 reference edges after the edge that first samples the last run's start bit, where SUM_W = `DLY_W`+clog2(`RUNS`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock, also the timestamp base |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request for a new measurement |
| data_in | input | 1 | Serial data line from the encoder |
| enc_clk | output | 1 | Interface clock to the encoder |
| enc_cmd | output | 1 | Command bit toward the encoder |
| enc_cmd_oe | output | 1 | Driver enable for the command line |
| delay_ticks | output | DLY_W | Averaged delay in reference ticks |
| meas_valid | output | 1 | Result complete and runs agree |
| meas_unreliable | output | 1 | Run spread above one eighth of the period |
| meas_timeout | output | 1 | A run saw no start bit |
| meas_done | output | 1 | One-cycle completion pulse |
| meas_busy | output | 1 | Measurement in progress |

## Verification
The bench acts as the encoder. It places each start bit a chosen number of reference cycles after an observed rising clock edge, so every run value is known in advance to be that count plus two. The final result is due exactly SUM_W+3 edges after the last start bit is first sampled. The bench counts negedges from the moment it raises `data_in` and expects `meas_done` on the SUM_W+4th of them. All outputs are sampled on falling reference edges, half a cycle after the registers that drive them update. The cases cover the spread exactly at the limit and one tick above it, a quotient that must round down, and a run with no reply.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

  // Lead periods before the command and command length in interface clocks.
  localparam int LEAD_PERIODS = 2;
  localparam int CMD_LEN      = 6;
  // Position read without extra data, followed by its redundant copy.
  localparam logic [CMD_LEN-1:0] CMD_POS_ONLY = 6'b000111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_RUN,
    ST_GAP,
    ST_KICK,
    ST_DIV
  } ldm_state_e;

endpackage

// File: rtl/ldm_frame_gen.sv
// Interface clock and command sequencer for one measurement run.
module ldm_frame_gen
  import ldm_pkg::*;
#(
  parameter int HALF_PERIOD = 1000,
  parameter int TMO_PERIODS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic stop,
  output logic iclk,
  output logic cmd_out,
  output logic cmd_oe,
  output logic listen,
  output logic rise_evt,
  output logic tmo_evt
);

  localparam int PHW      = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
  localparam int LISTEN_AT = LEAD_PERIODS + CMD_LEN;
  localparam int TMO_AT    = LISTEN_AT + TMO_PERIODS;
  localparam int FW        = $clog2(TMO_AT + 2);

  logic             active;
  logic [PHW-1:0]   ph;
  logic [FW-1:0]    fcnt;
  logic [CMD_LEN-1:0] cmd_sr;
  logic             hp;
  logic             fall_now;
  logic             in_cmd;

  assign hp       = active && (ph == PHW'(HALF_PERIOD - 1));
  assign fall_now = hp && iclk;
  assign rise_evt = hp && !iclk;
  assign in_cmd   = (fcnt >= FW'(LEAD_PERIODS)) && (fcnt < FW'(LISTEN_AT));
  assign tmo_evt  = fall_now && (fcnt == FW'(TMO_AT));

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      ph      <= '0;
      fcnt    <= '0;
      iclk    <= 1'b1;
      cmd_out <= 1'b0;
      cmd_oe  <= 1'b0;
      listen  <= 1'b0;
      cmd_sr  <= '0;
    end else if (stop) begin
      active  <= 1'b0;
      ph      <= '0;
      iclk    <= 1'b1;
      cmd_out <= 1'b0;
      cmd_oe  <= 1'b0;
      listen  <= 1'b0;
    end else if (go) begin
      active  <= 1'b1;
      ph      <= '0;
      fcnt    <= '0;
      iclk    <= 1'b1;
      cmd_out <= 1'b0;
      cmd_oe  <= 1'b1;
      listen  <= 1'b0;
      cmd_sr  <= CMD_POS_ONLY;
    end else if (active) begin
      ph <= hp ? '0 : ph + 1'b1;
      if (hp) iclk <= ~iclk;
      if (fall_now) begin
        fcnt <= fcnt + 1'b1;
        if (in_cmd) begin
          cmd_out <= cmd_sr[CMD_LEN-1];
          cmd_sr  <= {cmd_sr[CMD_LEN-2:0], 1'b0};
        end
        if (fcnt == FW'(LISTEN_AT)) begin
          cmd_oe  <= 1'b0;
          cmd_out <= 1'b0;
          listen  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ldm_edge_stamp.sv
// Free-running timestamp, rising-edge capture and start-bit detection.
module ldm_edge_stamp #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          listen,
  input  logic          rise_evt,
  input  logic          din,
  output logic          hit,
  output logic [TW-1:0] span
);

  logic [TW-1:0] ts;
  logic [TW-1:0] last_rise;
  logic          s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts        <= '0;
      last_rise <= '0;
      s1        <= 1'b0;
      s2        <= 1'b0;
    end else begin
      ts <= ts + 1'b1;
      s1 <= din;
      s2 <= s1;
      if (rise_evt) last_rise <= ts;
    end
  end

  // Wrap-safe difference; valid in the cycle where hit is high.
  assign hit  = listen && s1 && !s2;
  assign span = ts - last_rise;

endmodule

// File: rtl/ldm_div_const.sv
// Restoring divider by a constant, one quotient bit per cycle.
module ldm_div_const #(
  parameter int NW      = 18,
  parameter int QW      = 16,
  parameter int DIVISOR = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  output logic [QW-1:0] quo,
  output logic          done
);

  localparam int RW = $clog2(DIVISOR) + 1;
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] acc;
  logic [RW-1:0] rem;
  logic [RW-1:0] trial;
  logic [CW-1:0] cnt;
  logic          run;
  logic          ge;

  assign trial = {rem[RW-2:0], acc[NW-1]};
  assign ge    = trial >= RW'(DIVISOR);
  assign quo   = acc[QW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      rem  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        acc <= num;
        rem <= '0;
        cnt <= CW'(NW);
        run <= 1'b1;
      end else if (run) begin
        acc <= {acc[NW-2:0], ge};
        rem <= ge ? (trial - RW'(DIVISOR)) : trial;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/line_delay_meter.sv
// Power-up line delay measurement for a clocked serial encoder link.
module line_delay_meter
  import ldm_pkg::*;
#(
  parameter int HALF_PERIOD = 1000,
  parameter int DLY_W       = 16,
  parameter int RUNS        = 3,
  parameter int TMO_PERIODS = 8,
  parameter int GAP_PERIODS = 4,
  parameter bit AUTO_START  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             data_in,
  output logic             enc_clk,
  output logic             enc_cmd,
  output logic             enc_cmd_oe,
  output logic [DLY_W-1:0] delay_ticks,
  output logic             meas_valid,
  output logic             meas_unreliable,
  output logic             meas_timeout,
  output logic             meas_done,
  output logic             meas_busy
);

  localparam int SUM_W      = DLY_W + $clog2(RUNS);
  localparam int RUN_W      = $clog2(RUNS);
  localparam int SPREAD_LIM = (2 * HALF_PERIOD) / 8;
  localparam int GAP_TICKS  = GAP_PERIODS * 2 * HALF_PERIOD;
  localparam int GW         = $clog2(GAP_TICKS + 1);

  ldm_state_e       state;
  logic [RUN_W-1:0] run_idx;
  logic [GW-1:0]    gcnt;
  logic             auto_pend;

  logic             go, stop, listen, rise_evt, tmo_evt, hit;
  logic [DLY_W-1:0] span;
  logic             div_go, div_done;
  logic [DLY_W-1:0] div_q;

  logic [DLY_W-1:0] res [RUNS];
  logic [SUM_W-1:0] sum;
  logic [DLY_W-1:0] mx, mn;
  logic             too_wide;

  assign go     = (state == ST_LAUNCH);
  assign stop   = (state == ST_RUN) && (hit || tmo_evt);
  assign div_go = (state == ST_KICK);

  ldm_frame_gen #(
    .HALF_PERIOD (HALF_PERIOD),
    .TMO_PERIODS (TMO_PERIODS)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .stop     (stop),
    .iclk     (enc_clk),
    .cmd_out  (enc_cmd),
    .cmd_oe   (enc_cmd_oe),
    .listen   (listen),
    .rise_evt (rise_evt),
    .tmo_evt  (tmo_evt)
  );

  ldm_edge_stamp #(
    .TW (DLY_W)
  ) u_stamp (
    .clk      (clk),
    .rst      (rst),
    .listen   (listen),
    .rise_evt (rise_evt),
    .din      (data_in),
    .hit      (hit),
    .span     (span)
  );

  ldm_div_const #(
    .NW      (SUM_W),
    .QW      (DLY_W),
    .DIVISOR (RUNS)
  ) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go),
    .num  (sum),
    .quo  (div_q),
    .done (div_done)
  );

  // One result slot per run.
  for (genvar g = 0; g < RUNS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        res[g] <= '0;
      end else if ((state == ST_RUN) && hit && (run_idx == RUN_W'(g))) begin
        res[g] <= span;
      end
    end
  end

  always_comb begin
    sum = '0;
    mx  = res[0];
    mn  = res[0];
    for (int i = 0; i < RUNS; i++) begin
      sum = sum + SUM_W'(res[i]);
      if (res[i] > mx) mx = res[i];
      if (res[i] < mn) mn = res[i];
    end
    too_wide = (mx - mn) > DLY_W'(SPREAD_LIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      run_idx         <= '0;
      gcnt            <= '0;
      auto_pend       <= AUTO_START;
      delay_ticks     <= '0;
      meas_valid      <= 1'b0;
      meas_unreliable <= 1'b0;
      meas_timeout    <= 1'b0;
      meas_done       <= 1'b0;
      meas_busy       <= 1'b0;
    end else begin
      meas_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start || auto_pend) begin
            auto_pend       <= 1'b0;
            meas_busy       <= 1'b1;
            meas_valid      <= 1'b0;
            meas_unreliable <= 1'b0;
            meas_timeout    <= 1'b0;
            run_idx         <= '0;
            state           <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: state <= ST_RUN;
        ST_RUN: begin
          if (hit) begin
            if (run_idx == RUN_W'(RUNS - 1)) begin
              state <= ST_KICK;
            end else begin
              run_idx <= run_idx + 1'b1;
              gcnt    <= '0;
              state   <= ST_GAP;
            end
          end else if (tmo_evt) begin
            meas_timeout <= 1'b1;
            meas_done    <= 1'b1;
            meas_busy    <= 1'b0;
            state        <= ST_IDLE;
          end
        end
        ST_GAP: begin
          if (gcnt == GW'(GAP_TICKS - 1)) state <= ST_LAUNCH;
          else gcnt <= gcnt + 1'b1;
        end
        ST_KICK: state <= ST_DIV;
        ST_DIV: begin
          if (div_done) begin
            delay_ticks     <= div_q;
            meas_valid      <= !too_wide;
            meas_unreliable <= too_wide;
            meas_done       <= 1'b1;
            meas_busy       <= 1'b0;
            state           <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ldm_checker.sv
module ldm_checker #(
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enc_clk,
  input logic             enc_cmd_oe,
  input logic [DLY_W-1:0] delay_ticks,
  input logic             meas_valid,
  input logic             meas_unreliable,
  input logic             meas_timeout,
  input logic             meas_done,
  input logic             meas_busy
);

  // R2
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
    !meas_busy |-> enc_clk);

  // R3
  drive_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    enc_cmd_oe |-> meas_busy);

  // R3
  release_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(enc_cmd_oe) |-> !enc_clk);

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    meas_valid |-> !meas_unreliable);

  // R7
  tmo_clears_chk: assert property (@(posedge clk) disable iff (rst)
    meas_timeout |-> (!meas_valid && !meas_unreliable));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    meas_done |=> !meas_done);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(meas_busy) |-> meas_done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(delay_ticks) |-> meas_done);

endmodule

bind line_delay_meter ldm_checker #(.DLY_W(DLY_W)) u_ldm_chk (
  .clk             (clk),
  .rst             (rst),
  .enc_clk         (enc_clk),
  .enc_cmd_oe      (enc_cmd_oe),
  .delay_ticks     (delay_ticks),
  .meas_valid      (meas_valid),
  .meas_unreliable (meas_unreliable),
  .meas_timeout    (meas_timeout),
  .meas_done       (meas_done),
  .meas_busy       (meas_busy)
);

// File: tb/line_delay_meter_test.sv
`timescale 1ns/1ps
module line_delay_meter_test;

  localparam int HALF  = 16;
  localparam int DW    = 16;
  localparam int LIMIT = (2 * HALF) / 8;
  localparam int LAT   = DW + 2 + 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          data_in = 1'b0;
  logic          enc_clk, enc_cmd, enc_cmd_oe;
  logic [DW-1:0] delay_ticks;
  logic          meas_valid, meas_unreliable, meas_timeout, meas_done, meas_busy;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  line_delay_meter #(
    .HALF_PERIOD (HALF),
    .DLY_W       (DW),
    .RUNS        (3),
    .TMO_PERIODS (4),
    .GAP_PERIODS (2),
    .AUTO_START  (1'b1)
  ) uut (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .data_in         (data_in),
    .enc_clk         (enc_clk),
    .enc_cmd         (enc_cmd),
    .enc_cmd_oe      (enc_cmd_oe),
    .delay_ticks     (delay_ticks),
    .meas_valid      (meas_valid),
    .meas_unreliable (meas_unreliable),
    .meas_timeout    (meas_timeout),
    .meas_done       (meas_done),
    .meas_busy       (meas_busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_oe(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      if (enc_cmd_oe) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  // Plays the encoder for one run; returns negedges from start bit to done.
  task automatic enc_run(input int w, input int d, input bit last,
                         input bit check_frame, output int lat);
    bit ok;
    logic pclk;
    logic [7:0] bits;
    int nb, nr, cyc, t1, t2;
    lat = -1; bits = '0; nb = 0; nr = 0; cyc = 0; t1 = 0; t2 = 0;
    wait_oe(ok);
    chk(ok, "R3", "frame started", ok, 1);
    pclk = enc_clk;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cyc++;
      if (pclk && !enc_clk) begin
        if (enc_cmd_oe) begin bits = {bits[6:0], enc_cmd}; nb++; end
        else break;
      end
      if (!pclk && enc_clk) begin
        nr++;
        if (nr == 1) t1 = cyc;
        if (nr == 2) t2 = cyc;
      end
      pclk = enc_clk;
    end
    if (check_frame) begin
      chk(nb == 8, "R3", "driven slots", nb, 8);
      chk(bits == 8'b00000111, "R3", "command bits", bits, 7);
      chk((t2 - t1) == 2 * HALF, "R2", "clock period", t2 - t1, 2 * HALF);
    end
    pclk = enc_clk;
    nr = 0;
    while (nr < w) begin
      @(negedge clk);
      if (!pclk && enc_clk) nr++;
      pclk = enc_clk;
    end
    repeat (d) @(negedge clk);
    data_in = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 3) begin
        data_in = 1'b0;
        chk(enc_clk == 1'b1, "R2", "clock parked after start bit", enc_clk, 1);
        if (!last) break;
      end
      if (meas_done && lat < 0) lat = k;
    end
  endtask

  task automatic measure(input int d0, input int d1, input int d2,
                         input bit check_frame);
    int v[3];
    int s, mx, mn, lat, expq;
    bit wide;
    v[0] = d0 + 2; v[1] = d1 + 2; v[2] = d2 + 2;  // R4 run value = d+2
    s = v[0] + v[1] + v[2];
    mx = v[0]; mn = v[0];
    for (int i = 1; i < 3; i++) begin
      if (v[i] > mx) mx = v[i];
      if (v[i] < mn) mn = v[i];
    end
    expq = s / 3;
    wide = (mx - mn) > LIMIT;
    enc_run(1, d0, 0, check_frame, lat);
    enc_run(2, d1, 0, 0, lat);
    enc_run(3, d2, 1, 0, lat);
    chk(lat == LAT, "R10", "done latency", lat, LAT);
    chk(delay_ticks == DW'(expq), "R5", "averaged delay (R4 runs)", delay_ticks, expq);
    chk(meas_valid == !wide, "R6", "valid flag", meas_valid, !wide);
    chk(meas_unreliable == wide, "R6", "unreliable flag", meas_unreliable, wide);
    chk(meas_timeout == 1'b0, "R7", "no timeout", meas_timeout, 0);
    chk(meas_busy == 1'b0, "R8", "busy cleared", meas_busy, 0);
  endtask

  task automatic t_reset_auto();
    repeat (4) @(negedge clk);
    chk(enc_clk == 1'b1, "R2", "reset clock high", enc_clk, 1);
    chk(enc_cmd_oe == 1'b0, "R3", "reset driver off", enc_cmd_oe, 0);
    chk(delay_ticks == '0, "R8", "reset delay", delay_ticks, 0);
    chk(meas_valid == 1'b0, "R8", "reset valid", meas_valid, 0);
    chk(meas_busy == 1'b0, "R1", "reset busy", meas_busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(meas_busy == 1'b1, "R1", "auto start after reset", meas_busy, 1);
    measure(5, 6, 7, 1);
  endtask

  task automatic t_spread_limit();
    pulse_start();
    measure(3, 7, 5, 0);  // R6 spread equals the limit
  endtask

  task automatic t_spread_over();
    pulse_start();
    measure(3, 8, 3, 0);  // R6 spread one above the limit
  endtask

  task automatic t_timeout();
    bit ok;
    int n;
    logic [DW-1:0] prev;
    prev = delay_ticks;
    pulse_start();
    wait_oe(ok);
    n = 0;
    while (!meas_done && n < 2000) begin @(negedge clk); n++; end
    chk(meas_done == 1'b1, "R7", "done after silent run", meas_done, 1);
    chk(meas_timeout == 1'b1, "R7", "timeout flag", meas_timeout, 1);
    chk(meas_valid == 1'b0, "R7", "valid low on timeout", meas_valid, 0);
    chk(delay_ticks == prev, "R7", "delay unchanged", delay_ticks, prev);
    chk(enc_clk == 1'b1, "R7", "clock parked", enc_clk, 1);
  endtask

  task automatic t_busy_start();
    bit ok;
    bit seen;
    logic [DW-1:0] held;
    pulse_start();
    wait_oe(ok);
    pulse_start();         // R9 request while busy
    measure(0, 1, 1, 0);   // R5 quotient rounds down: 8/3 -> 2
    held = delay_ticks;
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (enc_cmd_oe || meas_busy) seen = 1;
    end
    chk(!seen, "R9", "no frame after busy start", seen, 0);
    chk(delay_ticks == held, "R8", "delay held", delay_ticks, held);
    chk(meas_valid == 1'b1, "R8", "valid held", meas_valid, 1);
  endtask

  task automatic t_restart();
    logic [DW-1:0] held;
    held = delay_ticks;
    pulse_start();
    chk(meas_valid == 1'b0, "R8", "start clears valid", meas_valid, 0);
    chk(delay_ticks == held, "R8", "start keeps delay", delay_ticks, held);
    measure(10, 12, 11, 0);
  endtask

  initial begin
    t_reset_auto();
    t_spread_limit();
    t_spread_over();
    t_timeout();
    t_busy_start();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule